// File: doc/BRIEF.md
# I2C Event Target Responder

This block stands in for one or more I2C targets on a bus that is modelled as a stream of 16-bit event words instead of SDA and SCL waveforms. The upper byte of each word is an opcode: a start carrying an address byte, a byte written by the controller, a request for a byte to be read, or a stop. The lower byte carries the address byte or the data. The event source waits for the answer to each event. For this reason a read request is answered combinationally, in the same cycle as the request.

For every 7-bit target address the block keeps a response byte that the host loads through a configuration port. A start latches the addressed target and the transfer direction. A read request in a read transfer returns the stored byte for that target. A write event in a write transfer raises a one-cycle strobe that carries the byte and the target address. Events that arrive outside a transfer, or that do not match the direction of the transfer, are ignored.

Top module: `i2c_evt_responder`

## Requirements
- R1: After reset no transfer is active (`sel_active`=0), `wr_strobe`=0, `rsp_valid`=0, `rsp_data`=0xFF, and every response entry is unconfigured.
- R2: An accepted event with opcode 0x01 (bits 15:8) starts a transfer. From the next cycle `sel_active`=1, `sel_addr` holds event bits 7:1 and `sel_read` holds event bit 0 (1 means read).
- R3: An event with opcode 0x03 during an active read transfer drives `rsp_valid`=1 in the same cycle, with `rsp_data` set to the response byte stored for `sel_addr`.
- R4: A read request to an address that has never been configured returns 0xFF. Whenever `rsp_valid` is 0, `rsp_data` is 0xFF.
- R5: A configuration write (`cfg_we`=1) stores `cfg_data` for `cfg_addr` and applies to events from the following cycle on. A later write to the same address replaces the byte. Other addresses are not affected.
- R6: An event with opcode 0x02 during an active write transfer pulses `wr_strobe` for exactly one cycle, in the cycle after the event. It comes with `wr_data` = event bits 7:0 and `wr_addr` = the latched target.
- R7: The event 0x0000 ends the transfer (`sel_active`=0 from the next cycle). Later read and write events are ignored until the next start.
- R8: Read and write events that arrive before any start produce no response and no strobe.
- R9: A start received during an active transfer (a repeated start) replaces the latched address and direction without an intervening stop.
- R10: A write event in a read transfer raises no strobe. A read request in a write transfer gives `rsp_valid`=0.
- R11: Opcodes 0x04 to 0xFF, and opcode 0x00 with a nonzero low byte, leave the transfer state unchanged.
- R12: While `evt_valid`=0 the event code is ignored, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event word present this cycle |
| evt_code | input | 16 | Event word: opcode in 15:8, payload in 7:0 |
| rsp_valid | output | 1 | Read request is being answered this cycle |
| rsp_data | output | 8 | Byte driven for the read request, 0xFF otherwise |
| cfg_we | input | 1 | Host configuration write enable |
| cfg_addr | input | 7 | Target address to configure |
| cfg_data | input | 8 | Response byte for that address |
| wr_strobe | output | 1 | One-cycle pulse for a byte written to the target |
| wr_data | output | 8 | Written byte |
| wr_addr | output | 7 | Target that received the byte |
| sel_active | output | 1 | A transfer is open |
| sel_addr | output | 7 | Latched target address |
| sel_read | output | 1 | Direction of the open transfer, 1 = read |

## Verification
The read answer is combinational. The bench therefore drives each event just after a falling edge and samples `rsp_valid` and `rsp_data` 1 ns later, before the rising edge that accepts the event. The transfer state and the write strobe are registered one stage deep. They are sampled 1 ns after the rising edge that accepts the event, and a following idle cycle confirms that the strobe falls again. A configuration write is expected to take effect only for events driven after the edge that captures it, so every read that follows a configuration starts on a later cycle.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  // width of the opcode field in an event word
  localparam int OP_W = 8;

  // opcode values; the event source depends on these exact codes
  localparam logic [OP_W-1:0] OP_STOP  = 8'h00;
  localparam logic [OP_W-1:0] OP_START = 8'h01;
  localparam logic [OP_W-1:0] OP_WRITE = 8'h02;
  localparam logic [OP_W-1:0] OP_READ  = 8'h03;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_START,
    EV_WRITE,
    EV_READ,
    EV_STOP
  } ev_kind_e;
endpackage

// File: rtl/i2cr_decode.sv
// Classifies one event word; anything unrecognised becomes EV_NONE.
module i2cr_decode
  import i2cr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int EVT_W = OP_W + DATA_W
) (
  input  logic              evt_valid,
  input  logic [EVT_W-1:0]  evt_code,
  output ev_kind_e          kind,
  output logic [DATA_W-1:0] payload
);
  logic [OP_W-1:0] op;

  always_comb begin
    op      = evt_code[EVT_W-1:DATA_W];
    payload = evt_code[DATA_W-1:0];
    kind    = EV_NONE;
    if (evt_valid) begin
      case (op)
        OP_START: kind = EV_START;
        OP_WRITE: kind = EV_WRITE;
        OP_READ:  kind = EV_READ;
        OP_STOP:  kind = (payload == '0) ? EV_STOP : EV_NONE;
        default:  kind = EV_NONE;
      endcase
    end
  end
endmodule

// File: rtl/i2cr_session.sv
// Tracks the open transfer and registers the write strobe.
module i2cr_session
  import i2cr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ev_kind_e          kind,
  input  logic [DATA_W-1:0] payload,
  output logic              active,
  output logic [ADDR_W-1:0] addr,
  output logic              is_read,
  output logic              rd_hit,
  output logic              wr_strobe,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] wr_addr
);
  logic wr_hit;

  always_comb begin
    rd_hit = (kind == EV_READ)  && active &&  is_read;
    wr_hit = (kind == EV_WRITE) && active && !is_read;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      addr      <= '0;
      is_read   <= 1'b0;
      wr_strobe <= 1'b0;
      wr_data   <= '0;
      wr_addr   <= '0;
    end else begin
      wr_strobe <= wr_hit;
      if (wr_hit) begin
        wr_data <= payload;
        wr_addr <= addr;
      end
      case (kind)
        EV_START: begin
          active  <= 1'b1;
          addr    <= payload[DATA_W-1:1];
          is_read <= payload[0];
        end
        EV_STOP: begin
          active  <= 1'b0;
          is_read <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cr_table.sv
// Per-address response bytes. The data array has a synchronous write and an
// asynchronous read with no reset, so it maps to distributed RAM; the
// separate valid vector carries the reset.
module i2cr_table #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = '1,
  localparam int ADDR_W = DATA_W - 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  set_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     set_q <= '0;
    else if (we) set_q[waddr] <= 1'b1;
  end

  always_comb begin
    rdata = set_q[raddr] ? mem[raddr] : FILL;
  end
endmodule

// File: rtl/i2c_evt_responder.sv
module i2c_evt_responder
  import i2cr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = '1,
  localparam int ADDR_W = DATA_W - 1,
  localparam int EVT_W = OP_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic [EVT_W-1:0]  evt_code,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              wr_strobe,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              sel_active,
  output logic [ADDR_W-1:0] sel_addr,
  output logic              sel_read
);
  ev_kind_e          kind;
  logic [DATA_W-1:0] payload;
  logic              rd_hit;
  logic [DATA_W-1:0] tbl_data;

  i2cr_decode #(.DATA_W(DATA_W)) u_decode (
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .kind      (kind),
    .payload   (payload)
  );

  i2cr_session #(.DATA_W(DATA_W)) u_session (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .payload   (payload),
    .active    (sel_active),
    .addr      (sel_addr),
    .is_read   (sel_read),
    .rd_hit    (rd_hit),
    .wr_strobe (wr_strobe),
    .wr_data   (wr_data),
    .wr_addr   (wr_addr)
  );

  i2cr_table #(.DATA_W(DATA_W), .FILL(FILL)) u_table (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (cfg_data),
    .raddr (sel_addr),
    .rdata (tbl_data)
  );

  // answered in the event's own cycle: the source is stalled on it
  always_comb begin
    rsp_valid = rd_hit;
    rsp_data  = rd_hit ? tbl_data : FILL;
  end
endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = '1,
  localparam int ADDR_W = DATA_W - 1,
  localparam int EVT_W = i2cr_pkg::OP_W + DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_valid,
  input logic [EVT_W-1:0]  evt_code,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              wr_strobe,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              sel_active,
  input logic [ADDR_W-1:0] sel_addr,
  input logic              sel_read
);
  logic [i2cr_pkg::OP_W-1:0] op;
  logic ev_start, ev_wr_ok, ev_rd, ev_stop;

  always_comb begin
    op       = evt_code[EVT_W-1:DATA_W];
    ev_start = evt_valid && (op == 8'h01);
    ev_stop  = evt_valid && (evt_code == '0);
    ev_rd    = evt_valid && (op == 8'h03);
    ev_wr_ok = evt_valid && (op == 8'h02) && sel_active && !sel_read;
  end

  assert_start_latch_R2: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> sel_active && sel_addr == $past(evt_code[DATA_W-1:1])
                 && sel_read == $past(evt_code[0]));

  assert_read_gate_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ev_rd && sel_active && sel_read);

  assert_idle_fill_R4: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> rsp_data == FILL);

  assert_write_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    ev_wr_ok |=> wr_strobe && wr_data == $past(evt_code[DATA_W-1:0])
                 && wr_addr == $past(sel_addr));

  assert_no_stray_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !ev_wr_ok |=> !wr_strobe);

  assert_stop_closes_R7: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> !sel_active);

  assert_state_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(ev_start || ev_stop) |=> sel_active == $past(sel_active)
                               && sel_addr == $past(sel_addr));
endmodule

bind i2c_evt_responder i2cr_checker #(.DATA_W(DATA_W), .FILL(FILL)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_valid  (evt_valid),
  .evt_code   (evt_code),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .wr_strobe  (wr_strobe),
  .wr_data    (wr_data),
  .wr_addr    (wr_addr),
  .sel_active (sel_active),
  .sel_addr   (sel_addr),
  .sel_read   (sel_read)
);

// File: tb/test_i2c_evt_responder.sv
`timescale 1ns/1ps
module test_i2c_evt_responder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [15:0] evt_code = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic        wr_strobe;
  logic [7:0]  wr_data;
  logic [6:0]  wr_addr;
  logic        sel_active;
  logic [6:0]  sel_addr;
  logic        sel_read;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic       c_rv;
  logic [7:0] c_rd;
  logic       c_ws;
  logic [7:0] c_wd;
  logic [6:0] c_wa;

  always #5 clk = ~clk;

  i2c_evt_responder i_i2c_evt_responder (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .wr_strobe(wr_strobe),
    .wr_data(wr_data), .wr_addr(wr_addr), .sel_active(sel_active),
    .sel_addr(sel_addr), .sel_read(sel_read)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle with the given valid/code; response captured before the edge,
  // registered outputs captured just after it
  task automatic cyc(input logic v, input logic [15:0] c);
    @(negedge clk);
    evt_valid = v;
    evt_code  = c;
    #1;
    c_rv = rsp_valid;
    c_rd = rsp_data;
    @(posedge clk);
    #1;
    c_ws = wr_strobe;
    c_wd = wr_data;
    c_wa = wr_addr;
    evt_valid = 1'b0;
    evt_code  = '0;
  endtask

  task automatic ev(input logic [15:0] c);
    cyc(1'b1, c);
  endtask

  task automatic cfg(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 active", sel_active, 0);
    check("R1 strobe", wr_strobe, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 rsp_data", rsp_data, 8'hFF);
  endtask

  task automatic t_pre_start();
    ev(16'h0255);
    check("R8 write before start", c_ws, 0);
    ev(16'h0300);
    check("R8 read before start valid", c_rv, 0);
    check("R8 read before start data", c_rd, 8'hFF);
  endtask

  task automatic t_cfg_read();
    cfg(7'h48, 8'h4B);
    ev(16'h0191);
    check("R2 active", sel_active, 1);
    check("R2 addr", sel_addr, 7'h48);
    check("R2 dir", sel_read, 1);
    ev(16'h0300);
    check("R3 valid", c_rv, 1);
    check("R3 data", c_rd, 8'h4B);
    ev(16'h0300);
    check("R3 repeat data", c_rd, 8'h4B);
    ev(16'h0000);
    check("R7 stop", sel_active, 0);
  endtask

  task automatic t_unconf();
    ev(16'h0121);
    ev(16'h0300);
    check("R4 unconfigured valid", c_rv, 1);
    check("R4 unconfigured data", c_rd, 8'hFF);
    ev(16'h0000);
  endtask

  task automatic t_write();
    ev(16'h0190);
    check("R2 write dir", sel_read, 0);
    ev(16'h02A5);
    check("R6 strobe", c_ws, 1);
    check("R6 data", c_wd, 8'hA5);
    check("R6 addr", c_wa, 7'h48);
    cyc(1'b0, 16'h0000);
    check("R6 single pulse", c_ws, 0);
    ev(16'h023C);
    check("R6 second data", c_wd, 8'h3C);
    ev(16'h0300);
    check("R10 read in write transfer", c_rv, 0);
    ev(16'h0000);
  endtask

  task automatic t_after_stop();
    check("R7 closed", sel_active, 0);
    ev(16'h0300);
    check("R7 read ignored", c_rv, 0);
    ev(16'h0211);
    check("R7 write ignored", c_ws, 0);
  endtask

  task automatic t_restart();
    cfg(7'h22, 8'h5A);
    ev(16'h0144);
    ev(16'h0201);
    check("R6 before restart", c_ws, 1);
    ev(16'h0145);
    check("R9 still active", sel_active, 1);
    check("R9 new dir", sel_read, 1);
    ev(16'h0300);
    check("R9 read after restart", c_rd, 8'h5A);
    ev(16'h0277);
    check("R10 write in read transfer", c_ws, 0);
    cfg(7'h22, 8'hC3);
    ev(16'h0300);
    check("R5 overwrite", c_rd, 8'hC3);
    ev(16'h0147);
    check("R9 neighbour addr", sel_addr, 7'h23);
    ev(16'h0300);
    check("R5 neighbour untouched", c_rd, 8'hFF);
    ev(16'h0145);
  endtask

  task automatic t_unknown();
    ev(16'h0455);
    check("R11 op 04 active", sel_active, 1);
    check("R11 op 04 addr", sel_addr, 7'h22);
    ev(16'h0001);
    check("R11 op 00 nonzero", sel_active, 1);
    ev(16'hFF00);
    check("R11 op FF", sel_addr, 7'h22);
    check("R11 no response", c_rv, 0);
  endtask

  task automatic t_idle();
    cyc(1'b0, 16'h0000);
    check("R12 stop code without valid", sel_active, 1);
    cyc(1'b0, 16'h0300);
    check("R12 read code without valid", c_rv, 0);
    cyc(1'b0, 16'h0102);
    check("R12 start code without valid", sel_addr, 7'h22);
    ev(16'h0000);
  endtask

  task automatic t_bounds();
    cfg(7'h7F, 8'h81);
    ev(16'h01FF);
    check("R2 top addr", sel_addr, 7'h7F);
    ev(16'h0300);
    check("R3 top addr data", c_rd, 8'h81);
    ev(16'h0101);
    check("R9 addr zero", sel_addr, 7'h00);
    ev(16'h0300);
    check("R4 addr zero unset", c_rd, 8'hFF);
    cfg(7'h00, 8'h00);
    ev(16'h0300);
    check("R5 addr zero data", c_rd, 8'h00);
    check("R5 addr zero valid", c_rv, 1);
    ev(16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pre_start();
    t_cfg_read();
    t_unconf();
    t_write();
    t_after_stop();
    t_restart();
    t_unknown();
    t_idle();
    t_bounds();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule